// File: doc/BRIEF.md
# YCbCr to RGB888 Streaming Converter

This block turns a stream of 32-bit YCbCr words into a stream of 24-bit RGB pixels. A word is either one packed 4:2:2 pair, which gives two pixels that share one Cb/Cr sample, or one pixel whose three bytes each hold one component. For each pixel the block subtracts a luma offset from Y and a chroma offset from Cb and Cr. It then forms three weighted sums with five unsigned coefficients in units of 1/1024, shifts each sum right by 10 and clamps it to the 8-bit range.

Both sides use valid/ready handshakes. The datapath has three register stages: word hold/unpack, offset subtraction with multiply, and sum with saturation. A small write port fills a staging copy of the coefficients and offsets. A commit strobe moves the whole staging copy into the working set in one edge, so a pixel never sees a mix of old and new values.

Top module: `ycc2rgb_conv`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The working set holds C0=0x4A8, C1=0x662, C2=0x191, C3=0x341, C4=0x811, a luma offset of 0 and a chroma offset of 128.
- R2: For each pixel, y = Y − luma offset, u = Cb − chroma offset and v = Cr − chroma offset, all as signed values.
- R3: The block forms R = C0·y + C1·v, G = C0·y − C2·u − C3·v and B = C0·y + C4·u. The output is `out_rgb` = {R[23:16], G[15:8], B[7:0]}.
- R4: Each sum is shifted arithmetically right by 10 bits and then clamped: a negative result gives 0 and a result above 255 gives 255.
- R5: With `in_packed`=1, `in_order` picks the byte layout, listed from bits 31:24 down to 7:0: 0 = Cr,Y1,Cb,Y0; 1 = Cb,Y1,Cr,Y0; 2 = Y1,Cr,Y0,Cb; 3 = Y1,Cb,Y0,Cr.
- R6: A packed word gives exactly two output pixels, the Y0 pixel first and then the Y1 pixel. Both use the word's Cb and Cr. The next word is not accepted until the second pixel leaves the hold stage.
- R7: With `in_packed`=0, a word is one pixel with Y in bits 7:0, Cb in 15:8 and Cr in 23:16. Bits 31:24 and `in_order` have no effect.
- R8: A `cfg_we` write with `cfg_sel` 0..4 (C0..C4), 5 (luma offset, low 8 bits) or 6 (chroma offset, low 8 bits) changes only the staging copy. Output pixels are unaffected until `cfg_commit` is pulsed. The pulse loads all staged values into the working set in one edge.
- R9: When `out_ready` is low, `out_valid` and `out_rgb` hold steady. Under any stall pattern every pixel comes out once, in order. With `out_ready` held high the block emits one pixel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Input word |
| in_packed | input | 1 | 1 = packed 4:2:2 pair, 0 = one pixel per word |
| in_order | input | 2 | Byte layout of a packed word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted on this edge when valid |
| out_rgb | output | 24 | Pixel {R,G,B} |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts the pixel |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_sel | input | 3 | Staging register select |
| cfg_data | input | 16 | Staging register write value |
| cfg_commit | input | 1 | Copy the staging set into the working set |

## Verification
One-pixel words are tested at grey, mid-range and extreme component values. These show whether the offsets are subtracted, whether each coefficient lands on the correct channel, and whether clamping works at both ends rather than wrapping. Packed words carry distinct Y0, Y1, Cb and Cr bytes in all four layouts, so a swapped lane, a wrong pixel order or a lost chroma share gives a different colour. Coefficient sets that reduce the matrix to an identity with a chosen offset separate staged writes from committed ones. A long run of packed words under a pseudo-random sink stall tests ordering, loss and duplication.

// File: rtl/ycc_pkg.sv
`timescale 1ns/1ps
package ycc_pkg;

   // Packed 4:2:2 byte layouts, named from the top byte down
   typedef enum logic [1:0] {
      LAYOUT_CR_Y1_CB_Y0 = 2'd0,
      LAYOUT_CB_Y1_CR_Y0 = 2'd1,
      LAYOUT_Y1_CR_Y0_CB = 2'd2,
      LAYOUT_Y1_CB_Y0_CR = 2'd3
   } layout_e;

   // Staging register select codes
   typedef enum logic [2:0] {
      CSEL_K0    = 3'd0,
      CSEL_K1    = 3'd1,
      CSEL_K2    = 3'd2,
      CSEL_K3    = 3'd3,
      CSEL_K4    = 3'd4,
      CSEL_YOFF  = 3'd5,
      CSEL_COFF  = 3'd6,
      CSEL_NONE  = 3'd7
   } csel_e;

   localparam int NUM_COEF = 5;
   localparam int NUM_CHAN = 3;

endpackage

// File: rtl/ycc_cfg_regs.sv
`timescale 1ns/1ps
module ycc_cfg_regs
   import ycc_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 12,
   parameter int DEF_K0 = 'h4A8,
   parameter int DEF_K1 = 'h662,
   parameter int DEF_K2 = 'h191,
   parameter int DEF_K3 = 'h341,
   parameter int DEF_K4 = 'h811,
   parameter int DEF_YOFF = 0,
   parameter int DEF_COFF = 128
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [2:0]                        wr_sel,
   input  logic [15:0]                       wr_data,
   input  logic                              commit,
   output logic [NUM_COEF-1:0][COEF_W-1:0]   act_coef,
   output logic [PIX_W-1:0]                  act_yoff,
   output logic [PIX_W-1:0]                  act_coff
);

   logic [NUM_COEF-1:0][COEF_W-1:0] stg_coef;
   logic [PIX_W-1:0]                stg_yoff;
   logic [PIX_W-1:0]                stg_coff;
   logic                            wr_hi_unused;

   assign wr_hi_unused = ^wr_data[15:COEF_W];

   for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
      localparam int DV = (k == 0) ? DEF_K0 : (k == 1) ? DEF_K1 :
                          (k == 2) ? DEF_K2 : (k == 3) ? DEF_K3 : DEF_K4;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_coef[k] <= COEF_W'(DV);
            act_coef[k] <= COEF_W'(DV);
         end else begin
            if (wr_en && wr_sel == 3'(k)) stg_coef[k] <= wr_data[COEF_W-1:0];
            if (commit)                   act_coef[k] <= stg_coef[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_yoff <= PIX_W'(DEF_YOFF);
         stg_coff <= PIX_W'(DEF_COFF);
         act_yoff <= PIX_W'(DEF_YOFF);
         act_coff <= PIX_W'(DEF_COFF);
      end else begin
         if (wr_en && wr_sel == CSEL_YOFF) stg_yoff <= wr_data[PIX_W-1:0];
         if (wr_en && wr_sel == CSEL_COFF) stg_coff <= wr_data[PIX_W-1:0];
         if (commit) begin
            act_yoff <= stg_yoff;
            act_coff <= stg_coff;
         end
      end
   end

   // R8: working set moves only on a commit pulse
   assert_hold_without_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(act_coef) && $stable(act_yoff) && $stable(act_coff)));

endmodule

// File: rtl/ycc_unpack.sv
`timescale 1ns/1ps
module ycc_unpack
   import ycc_pkg::*;
#(
   parameter int PIX_W = 8,
   localparam int WORD_W = 4 * PIX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  in_data,
   input  logic               in_packed,
   input  logic [1:0]         in_order,
   input  logic               in_valid,
   output logic               in_ready,
   output logic               pix_valid,
   input  logic               pix_take,
   output logic [PIX_W-1:0]   pix_y,
   output logic [PIX_W-1:0]   pix_u,
   output logic [PIX_W-1:0]   pix_v
);

   logic [WORD_W-1:0] word_q;
   logic              packed_q;
   layout_e           order_q;
   logic              phase_q;
   logic              hold_q;
   logic              last_pix;
   logic              pop;
   logic [PIX_W-1:0]  lane [4];
   logic [PIX_W-1:0]  y0, y1, cb, cr;

   for (genvar b = 0; b < 4; b++) begin : g_lane
      assign lane[b] = word_q[b*PIX_W +: PIX_W];
   end

   always_comb begin
      unique case (order_q)
         LAYOUT_CR_Y1_CB_Y0: begin y0 = lane[0]; cb = lane[1]; y1 = lane[2]; cr = lane[3]; end
         LAYOUT_CB_Y1_CR_Y0: begin y0 = lane[0]; cr = lane[1]; y1 = lane[2]; cb = lane[3]; end
         LAYOUT_Y1_CR_Y0_CB: begin cb = lane[0]; y0 = lane[1]; cr = lane[2]; y1 = lane[3]; end
         default:            begin cr = lane[0]; y0 = lane[1]; cb = lane[2]; y1 = lane[3]; end
      endcase
      if (packed_q) begin
         pix_y = phase_q ? y1 : y0;
         pix_u = cb;
         pix_v = cr;
      end else begin
         pix_y = lane[0];
         pix_u = lane[1];
         pix_v = lane[2];
      end
   end

   assign last_pix  = !packed_q || phase_q;
   assign pop       = hold_q && pix_take;
   assign pix_valid = hold_q;
   assign in_ready  = !hold_q || (pix_take && last_pix);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         packed_q <= 1'b0;
         order_q  <= LAYOUT_CR_Y1_CB_Y0;
         phase_q  <= 1'b0;
         hold_q   <= 1'b0;
      end else if (in_valid && in_ready) begin
         word_q   <= in_data;
         packed_q <= in_packed;
         order_q  <= layout_e'(in_order);
         phase_q  <= 1'b0;
         hold_q   <= 1'b1;
      end else if (pop) begin
         if (last_pix) hold_q  <= 1'b0;
         else          phase_q <= 1'b1;
      end
   end

   // R6: first half of a pair is always followed by its second half
   assert_pair_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && packed_q && !phase_q && pix_take) |=> (hold_q && phase_q));

   // R6: no new word while the second pixel is still owed
   assert_pair_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && packed_q && !phase_q) |-> !in_ready);

endmodule

// File: rtl/ycc_mac_stage.sv
`timescale 1ns/1ps
module ycc_mac_stage
   import ycc_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 12,
   localparam int DIFF_W = PIX_W + 2,
   localparam int PROD_W = COEF_W + 1 + DIFF_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              up_valid,
   output logic                              up_ready,
   input  logic [PIX_W-1:0]                  in_y,
   input  logic [PIX_W-1:0]                  in_u,
   input  logic [PIX_W-1:0]                  in_v,
   input  logic [NUM_COEF-1:0][COEF_W-1:0]   coef,
   input  logic [PIX_W-1:0]                  yoff,
   input  logic [PIX_W-1:0]                  coff,
   output logic                              dn_valid,
   input  logic                              dn_ready,
   output logic [NUM_COEF-1:0][PROD_W-1:0]   prod
);

   logic signed [DIFF_W-1:0] dy, du, dv;
   logic [NUM_COEF-1:0][PROD_W-1:0] prod_d;

   assign dy = $signed({2'b00, in_y}) - $signed({2'b00, yoff});
   assign du = $signed({2'b00, in_u}) - $signed({2'b00, coff});
   assign dv = $signed({2'b00, in_v}) - $signed({2'b00, coff});

   // k0 weights luma, k1/k3 weight Cr, k2/k4 weight Cb
   for (genvar k = 0; k < NUM_COEF; k++) begin : g_mul
      logic signed [DIFF_W-1:0] opnd;
      if (k == 0) begin : g_luma
         assign opnd = dy;
      end else if (k == 1 || k == 3) begin : g_cr
         assign opnd = dv;
      end else begin : g_cb
         assign opnd = du;
      end
      assign prod_d[k] = PROD_W'($signed({1'b0, coef[k]}) * opnd);
   end

   assign up_ready = !dn_valid || dn_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         prod     <= '0;
      end else if (up_ready) begin
         dn_valid <= up_valid;
         if (up_valid) prod <= prod_d;
      end
   end

endmodule

// File: rtl/ycc_sat_stage.sv
`timescale 1ns/1ps
module ycc_sat_stage
   import ycc_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 12,
   parameter int FRAC_W = 10,
   localparam int DIFF_W = PIX_W + 2,
   localparam int PROD_W = COEF_W + 1 + DIFF_W,
   localparam int SUM_W  = PROD_W + 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              up_valid,
   output logic                              up_ready,
   input  logic [NUM_COEF-1:0][PROD_W-1:0]   prod,
   output logic                              out_valid,
   input  logic                              out_ready,
   output logic [NUM_CHAN*PIX_W-1:0]         out_rgb
);

   localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

   logic signed [SUM_W-1:0] p [NUM_COEF];
   logic signed [SUM_W-1:0] ch_sum [NUM_CHAN];
   logic [NUM_CHAN*PIX_W-1:0] rgb_d;

   for (genvar k = 0; k < NUM_COEF; k++) begin : g_ext
      assign p[k] = SUM_W'($signed(prod[k]));
   end

   assign ch_sum[0] = p[0] + p[1];
   assign ch_sum[1] = p[0] - p[2] - p[3];
   assign ch_sum[2] = p[0] + p[4];

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic signed [SUM_W-1:0] sh;
      logic [PIX_W-1:0]        clamped;
      assign sh = ch_sum[c] >>> FRAC_W;
      always_comb begin
         if (sh < 0)         clamped = '0;
         else if (sh > MAXV) clamped = '1;
         else                clamped = sh[PIX_W-1:0];
      end
      assign rgb_d[(NUM_CHAN-c)*PIX_W-1 -: PIX_W] = clamped;
   end

   assign up_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else if (up_ready) begin
         out_valid <= up_valid;
         if (up_valid) out_rgb <= rgb_d;
      end
   end

   // R9: a stalled pixel stays put
   assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

endmodule

// File: rtl/ycc2rgb_conv.sv
`timescale 1ns/1ps
module ycc2rgb_conv
   import ycc_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int COEF_W   = 12,
   parameter int FRAC_W   = 10,
   parameter int DEF_K0   = 'h4A8,
   parameter int DEF_K1   = 'h662,
   parameter int DEF_K2   = 'h191,
   parameter int DEF_K3   = 'h341,
   parameter int DEF_K4   = 'h811,
   parameter int DEF_YOFF = 0,
   parameter int DEF_COFF = 128,
   localparam int WORD_W  = 4 * PIX_W,
   localparam int RGB_W   = NUM_CHAN * PIX_W,
   localparam int PROD_W  = COEF_W + 1 + PIX_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  in_data,
   input  logic               in_packed,
   input  logic [1:0]         in_order,
   input  logic               in_valid,
   output logic               in_ready,
   output logic [RGB_W-1:0]   out_rgb,
   output logic               out_valid,
   input  logic               out_ready,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [15:0]        cfg_data,
   input  logic               cfg_commit
);

   if (PIX_W < 4 || PIX_W > 12) begin : g_bad_pix
      $error("PIX_W out of range");
   end
   if (COEF_W <= PIX_W || COEF_W > 16) begin : g_bad_coef
      $error("COEF_W must exceed PIX_W and fit the write port");
   end
   if (FRAC_W < 1 || FRAC_W >= COEF_W + PIX_W) begin : g_bad_frac
      $error("FRAC_W out of range");
   end

   logic [NUM_COEF-1:0][COEF_W-1:0] act_coef;
   logic [PIX_W-1:0]                act_yoff, act_coff;
   logic                            s1_valid, s2_ready, s2_valid, s3_ready;
   logic [PIX_W-1:0]                s1_y, s1_u, s1_v;
   logic [NUM_COEF-1:0][PROD_W-1:0] s2_prod;

   ycc_cfg_regs #(
      .PIX_W(PIX_W), .COEF_W(COEF_W),
      .DEF_K0(DEF_K0), .DEF_K1(DEF_K1), .DEF_K2(DEF_K2),
      .DEF_K3(DEF_K3), .DEF_K4(DEF_K4),
      .DEF_YOFF(DEF_YOFF), .DEF_COFF(DEF_COFF)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_data), .commit(cfg_commit),
      .act_coef(act_coef), .act_yoff(act_yoff), .act_coff(act_coff)
   );

   ycc_unpack #(.PIX_W(PIX_W)) u_unpack (
      .clk(clk), .rst_n(rst_n),
      .in_data(in_data), .in_packed(in_packed), .in_order(in_order),
      .in_valid(in_valid), .in_ready(in_ready),
      .pix_valid(s1_valid), .pix_take(s2_ready),
      .pix_y(s1_y), .pix_u(s1_u), .pix_v(s1_v)
   );

   ycc_mac_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mac (
      .clk(clk), .rst_n(rst_n),
      .up_valid(s1_valid), .up_ready(s2_ready),
      .in_y(s1_y), .in_u(s1_u), .in_v(s1_v),
      .coef(act_coef), .yoff(act_yoff), .coff(act_coff),
      .dn_valid(s2_valid), .dn_ready(s3_ready), .prod(s2_prod)
   );

   ycc_sat_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_sat (
      .clk(clk), .rst_n(rst_n),
      .up_valid(s2_valid), .up_ready(s3_ready), .prod(s2_prod),
      .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
   );

   // R1: reset empties the output stage
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   // R9: an output appears only after something entered the pipeline
   assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !s2_valid) |=> !out_valid);

endmodule

// File: tb/ycc2rgb_conv_bench.sv
`timescale 1ns/1ps
module ycc2rgb_conv_bench;

   typedef struct {
      logic [23:0] rgb;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_packed = 1'b0;
   logic [1:0]  in_order = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [23:0] out_rgb;
   logic        out_valid;
   logic        out_ready;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_data = '0;
   logic        cfg_commit = 1'b0;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;
   bit   stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   exp_t expq[$];

   int m_c[5] = '{'h4A8, 'h662, 'h191, 'h341, 'h811};
   int m_yoff = 0;
   int m_coff = 128;

   always #2.5 clk = ~clk;

   ycc2rgb_conv u_ycc2rgb_conv (
      .clk(clk), .rst_n(rst_n),
      .in_data(in_data), .in_packed(in_packed), .in_order(in_order),
      .in_valid(in_valid), .in_ready(in_ready),
      .out_rgb(out_rgb), .out_valid(out_valid), .out_ready(out_ready),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .cfg_commit(cfg_commit)
   );

   function automatic int clamp8(int s);
      if (s < 0) return 0;
      if (s > 255) return 255;
      return s;
   endfunction

   function automatic logic [23:0] model(int yb, int ub, int vb);
      int y, u, v, r, g, b;
      y = yb - m_yoff;
      u = ub - m_coff;
      v = vb - m_coff;
      r = clamp8((m_c[0]*y + m_c[1]*v) >>> 10);
      g = clamp8((m_c[0]*y - m_c[2]*u - m_c[3]*v) >>> 10);
      b = clamp8((m_c[0]*y + m_c[4]*u) >>> 10);
      return {r[7:0], g[7:0], b[7:0]};
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic push(int yb, int ub, int vb, string tag);
      exp_t e;
      e.rgb = model(yb, ub, vb);
      e.tag = tag;
      expq.push_back(e);
   endtask

   // sink side: sets ready for the coming edge, then scores the transfer
   initial begin
      out_ready = 1'b1;
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = stall_en ? (lfsr[0] | lfsr[5]) : 1'b1;
         #0.5;
         if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
               n_checks++;
               n_fails++;
               $display("FAIL R9: got unexpected pixel %0h expected none", out_rgb);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(e.tag, {8'h0, out_rgb}, {8'h0, e.rgb});
            end
         end
      end
   end

   task automatic send(logic [31:0] w, logic pk, logic [1:0] ord);
      bit ok;
      @(negedge clk);
      in_data = w; in_packed = pk; in_order = ord; in_valid = 1'b1;
      forever begin
         #1;
         ok = in_ready;
         @(posedge clk);
         if (ok) break;
         @(negedge clk);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain(string tag);
      idle();
      for (int i = 0; i < 400 && expq.size() > 0; i++) @(negedge clk);
      check(tag, expq.size(), 0);
   endtask

   task automatic cfg_write(logic [2:0] sel, logic [15:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_pulse();
      @(negedge clk);
      cfg_commit = 1'b1;
      @(negedge clk);
      cfg_commit = 1'b0;
   endtask

   task automatic send_pixel(int y, int u, int v, logic [7:0] junk, string tag);
      push(y, u, v, tag);
      send({junk, v[7:0], u[7:0], y[7:0]}, 1'b0, 2'd3);
   endtask

   task automatic send_pair(int y0, int y1, int u, int v, int ord, string tag);
      logic [7:0] a, b, c, d;
      a = y0[7:0]; b = y1[7:0]; c = u[7:0]; d = v[7:0];
      push(y0, u, v, tag);
      push(y1, u, v, "R6");
      case (ord)
         0:       send({d, b, c, a}, 1'b1, 2'd0);
         1:       send({c, b, d, a}, 1'b1, 2'd1);
         2:       send({b, d, a, c}, 1'b1, 2'd2);
         default: send({b, c, a, d}, 1'b1, 2'd3);
      endcase
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      check("R1 out_valid", {31'b0, out_valid}, 0);
      check("R1 in_ready", {31'b0, in_ready}, 1);
   endtask

   task automatic t_single();
      send_pixel(16, 128, 128, 8'hFF, "R2");
      send_pixel(81, 90, 240, 8'h5A, "R7");
      send_pixel(145, 54, 34, 8'h00, "R3");
      send_pixel(41, 240, 110, 8'hC3, "R3");
      drain("R7 drain");
   endtask

   task automatic t_saturate();
      send_pixel(255, 255, 255, 8'h11, "R4 high");
      send_pixel(0, 0, 0, 8'h22, "R4 low");
      send_pixel(235, 128, 128, 8'h33, "R4 white");
      send_pixel(0, 128, 255, 8'h44, "R4 mixed");
      drain("R4 drain");
   endtask

   task automatic t_layouts();
      for (int o = 0; o < 4; o++) begin
         send_pair(8'h50, 8'hA0, 8'h60, 8'hB0, o, "R5");
         send_pair(8'hE0, 8'h20, 8'hC8, 8'h30, o, "R5");
      end
      drain("R5 drain");
   endtask

   task automatic t_config();
      cfg_write(3'd0, 16'h0400);
      cfg_write(3'd1, 16'h0000);
      cfg_write(3'd2, 16'h0000);
      cfg_write(3'd3, 16'h0000);
      cfg_write(3'd4, 16'h0000);
      cfg_write(3'd5, 16'h0010);
      send_pixel(100, 50, 200, 8'h00, "R8 staged only");
      drain("R8 drain");
      cfg_pulse();
      m_c = '{1024, 0, 0, 0, 0};
      m_yoff = 16;
      send_pixel(100, 50, 200, 8'h00, "R8 luma offset");
      drain("R8 drain");
      check("R8 identity", {8'h0, model(100, 50, 200)}, {8'h0, 24'h545454});
      cfg_write(3'd1, 16'h0400);
      cfg_write(3'd4, 16'h0400);
      cfg_write(3'd6, 16'h0064);
      cfg_pulse();
      m_c = '{1024, 1024, 0, 0, 1024};
      m_coff = 100;
      send_pixel(16, 150, 120, 8'h00, "R8 chroma offset");
      drain("R8 drain");
      cfg_write(3'd0, 16'h04A8);
      cfg_write(3'd1, 16'h0662);
      cfg_write(3'd2, 16'h0191);
      cfg_write(3'd3, 16'h0341);
      cfg_write(3'd4, 16'h0811);
      cfg_write(3'd5, 16'h0000);
      cfg_write(3'd6, 16'h0080);
      cfg_pulse();
      m_c = '{'h4A8, 'h662, 'h191, 'h341, 'h811};
      m_yoff = 0;
      m_coff = 128;
      send_pixel(81, 90, 240, 8'h00, "R8 restore");
      drain("R8 drain");
   endtask

   task automatic t_stall();
      logic [31:0] w;
      stall_en = 1'b1;
      w = 32'h1357_9BDF;
      for (int i = 0; i < 24; i++) begin
         w = w * 32'd1664525 + 32'd1013904223;
         send_pair(int'(w[7:0]), int'(w[15:8]), int'(w[23:16]), int'(w[31:24]), i % 4, "R9");
      end
      for (int i = 0; i < 6; i++) begin
         w = w * 32'd1664525 + 32'd1013904223;
         send_pixel(int'(w[7:0]), int'(w[15:8]), int'(w[23:16]), w[31:24], "R9");
      end
      drain("R9 drain");
      stall_en = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_saturate();
      t_layouts();
      t_config();
      t_stall();
      repeat (4) @(negedge clk);
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

endmodule